// File: doc/BRIEF.md
# Windowed Watchdog Timer with Low-Power Freeze

This block is a supervision counter that advances on a slow-clock enable strobe inside the system clock domain. Software must restart it from time to time by writing a fixed key byte. The write is accepted only while a restart window is open near the end of the period. A late restart lets the counter run out. An early restart or a wrong byte counts as a fault. In either case the block raises a one-cycle reset request for the chip's reset generator.

The period and window size come from a configuration field. The block captures that field during reset and again at every reset request it raises, so the running period cannot change under software's feet. One combination of period and window is not allowed. The block reports it on a flag and holds the counter still. A lock bit decides whether the low-power inputs (halt, stop, oscillator off) freeze the count. A freeze keeps the count and never clears it.

Top module: `win_watchdog`

## Requirements
- R1: With period select N (0 to 7), the counter overflows after 2^(10+N) strobes. It then raises `rst_req_o` for one cycle and clears `count_o` to 0 on the same edge.
- R2: `count_o` advances by one only in cycles where `tick_i` is 1. When `tick_i` is 0 it holds its value.
- R3: With window select W, `win_open_o` is 1 when `count_o` >= P - (W+1)·P/4, where P is the period. The encodings are W=0 for the last quarter, W=1 for the last half, W=2 for the last three quarters, and W=3 for the whole period.
- R4: A write of 0xAC while the window is open clears `count_o` to 0 on the next edge and raises no reset request.
- R5: A write of any byte other than 0xAC, or a write of 0xAC while the window is closed, raises `rst_req_o` in the following cycle and clears the count.
- R6: `rst_req_o` is high for exactly one cycle. On that same edge the period and window inputs are captured again, and counting restarts from 0 under the new setting.
- R7: Period select 0 together with window select 0 raises `cfg_bad_o`. While this setting is active the count stays at 0, writes are ignored, and no reset request is raised.
- R8: With `osc_lock_i` = 0, `halt_i` or `stop_i` holds the count. After release the count continues from the held value.
- R9: With `osc_lock_i` = 0, `osc_off_i` holds the count without clearing it.
- R10: With `osc_lock_i` = 1, counting goes on through halt, stop and oscillator-off requests. No input pauses the count for flash programming.
- R11: During and right after reset, `count_o` is 0 and `rst_req_o` is 0. The configuration in force is the one present at the reset inputs.
- R12: A valid 0xAC write in the cycle where the count would overflow wins. The count clears and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle slow-clock strobe |
| period_sel_i | input | 3 | Overflow period select N, period 2^(10+N) strobes |
| window_sel_i | input | 2 | Restart window size select |
| osc_lock_i | input | 1 | 1: oscillator cannot be stopped, low-power inputs ignored |
| halt_i | input | 1 | Halt mode active |
| stop_i | input | 1 | Stop mode active |
| osc_off_i | input | 1 | Software oscillator stop request |
| kick_valid_i | input | 1 | Write strobe to the restart register |
| kick_data_i | input | 8 | Byte written to the restart register |
| rst_req_o | output | 1 | One-cycle reset request |
| cfg_bad_o | output | 1 | Prohibited configuration captured |
| win_open_o | output | 1 | Restart window currently open |
| count_o | output | 17 | Current count |

## Verification
Restart writes are placed one strobe before and exactly at the window threshold for every window size and for several periods. This separates an off-by-one threshold from a wrong quarter fraction. Wrong keys, writes at the terminal count, and writes under the prohibited setting separate the three write outcomes: clear, fault, and ignore. Low-power inputs are applied with the lock bit at 0 and at 1, and the count is read before and after release. This separates a freeze from a clear, and a freeze from free running.

// File: rtl/wdog_pkg.sv
// Shared constants for the windowed watchdog.
// Assumes: the slow clock arrives as an enable strobe in the system clock domain.
package wdog_pkg;
    localparam int BASE_EXP_D = 10;   // exponent of the shortest period
    localparam int SEL_W_D    = 3;    // period select width
    localparam int WIN_W_D    = 2;    // window select width
    localparam int DATA_W_D   = 8;    // restart register width
    localparam logic [7:0] KEY_D = 8'hAC;

    // Counter width that holds the longest period minus one.
    function automatic int cnt_width(input int base_exp, input int sel_w);
        return base_exp + (2 ** sel_w) - 1;
    endfunction
endpackage

// File: rtl/wdog_limits.sv
// Decodes the captured period and window selects into the terminal count
// and the first count of the open window. It also flags the prohibited
// all-zero combination.
// Assumes: the window fraction is (W+1)/2^WIN_W of the period, counted back from the end.
module wdog_limits #(
    parameter int BASE_EXP = wdog_pkg::BASE_EXP_D,
    parameter int SEL_W    = wdog_pkg::SEL_W_D,
    parameter int WIN_W    = wdog_pkg::WIN_W_D,
    parameter int CNT_W    = wdog_pkg::cnt_width(BASE_EXP, SEL_W)
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WIN_W-1:0] win_i,
    output logic [CNT_W-1:0] last_o,
    output logic [CNT_W-1:0] open_from_o,
    output logic             bad_o
);
    localparam int NSEL = 2 ** SEL_W;
    localparam int PW   = CNT_W + 1;

    logic [PW-1:0] span [NSEL];
    logic [PW-1:0] period;
    logic [PW-1:0] slice;
    logic [PW-1:0] shut;

    // One period constant per select value.
    for (genvar g = 0; g < NSEL; g++) begin : g_span
        assign span[g] = PW'(1) << (BASE_EXP + g);
    end

    // Derive the terminal count and the window threshold from the selected period.
    always_comb begin
        period      = span[sel_i];
        slice       = period >> WIN_W;
        shut        = slice * PW'(win_i) + slice;
        last_o      = CNT_W'(period - PW'(1));
        open_from_o = CNT_W'(period - shut);
    end

    // Flag the prohibited combination.
    assign bad_o = (sel_i == '0) && (win_i == '0);
endmodule

// File: rtl/wdog_gate.sv
// Decides whether the counter may advance in this cycle. The low-power
// inputs only take effect while the oscillator is not locked.
// Assumes: the inputs are synchronous to clk_i.
module wdog_gate (
    input  logic tick_i,
    input  logic hold_i,
    input  logic lock_i,
    input  logic halt_i,
    input  logic stop_i,
    input  logic osc_off_i,
    output logic advance_o
);
    logic freeze;

    // A freeze applies only while the oscillator may be stopped.
    always_comb begin
        freeze    = !lock_i && (halt_i || stop_i || osc_off_i);
        advance_o = tick_i && !hold_i && !freeze;
    end
endmodule

// File: rtl/wdog_counter.sv
// Up-counter with a synchronous clear. It reports when an advance would
// step past the terminal count.
// Assumes: the clear takes priority over an advance.
module wdog_counter #(
    parameter int CNT_W = wdog_pkg::cnt_width(wdog_pkg::BASE_EXP_D, wdog_pkg::SEL_W_D)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             advance_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: reset, clear, then advance.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Overflow happens when the terminal count is advanced.
    assign wrap_o  = advance_i && (cnt_q == last_i);
    assign count_o = cnt_q;
endmodule

// File: rtl/win_watchdog.sv
// Top of the windowed watchdog. It captures the configuration, checks
// restart writes against the key and the window, and raises a one-cycle
// reset request on a fault or an overflow.
// Assumes: the external reset generator acts on rst_req_o. The configuration
// inputs are only captured during reset and at each reset request.
module win_watchdog #(
    parameter int         BASE_EXP = wdog_pkg::BASE_EXP_D,
    parameter int         SEL_W    = wdog_pkg::SEL_W_D,
    parameter int         WIN_W    = wdog_pkg::WIN_W_D,
    parameter int         DATA_W   = wdog_pkg::DATA_W_D,
    parameter logic [7:0] KEY      = wdog_pkg::KEY_D,
    parameter int         CNT_W    = wdog_pkg::cnt_width(BASE_EXP, SEL_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [SEL_W-1:0]  period_sel_i,
    input  logic [WIN_W-1:0]  window_sel_i,
    input  logic              osc_lock_i,
    input  logic              halt_i,
    input  logic              stop_i,
    input  logic              osc_off_i,
    input  logic              kick_valid_i,
    input  logic [DATA_W-1:0] kick_data_i,
    output logic              rst_req_o,
    output logic              cfg_bad_o,
    output logic              win_open_o,
    output logic [CNT_W-1:0]  count_o
);
    logic [SEL_W-1:0] sel_q;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] open_from;
    logic             bad;
    logic             advance;
    logic             wrap;
    logic             key_ok;
    logic             good_kick;
    logic             bad_kick;
    logic             fire;
    logic             clear;
    logic             req_q;

    wdog_limits #(
        .BASE_EXP (BASE_EXP),
        .SEL_W    (SEL_W),
        .WIN_W    (WIN_W),
        .CNT_W    (CNT_W)
    ) u_limits (
        .sel_i       (sel_q),
        .win_i       (win_q),
        .last_o      (last_val),
        .open_from_o (open_from),
        .bad_o       (bad)
    );

    wdog_gate u_gate (
        .tick_i    (tick_i),
        .hold_i    (bad),
        .lock_i    (osc_lock_i),
        .halt_i    (halt_i),
        .stop_i    (stop_i),
        .osc_off_i (osc_off_i),
        .advance_o (advance)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .advance_i (advance),
        .clear_i   (clear),
        .last_i    (last_val),
        .count_o   (count_o),
        .wrap_o    (wrap)
    );

    // Classify a restart write. An overflow loses to a valid write in the same cycle.
    always_comb begin
        win_open_o = !bad && (count_o >= open_from);
        key_ok     = (kick_data_i == DATA_W'(KEY));
        good_kick  = kick_valid_i && !bad && key_ok && win_open_o;
        bad_kick   = kick_valid_i && !bad && !(key_ok && win_open_o);
        fire       = bad_kick || (wrap && !good_kick);
        clear      = fire || good_kick;
    end

    // Capture the configuration during reset and at every reset request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || fire) begin
            sel_q <= period_sel_i;
            win_q <= window_sel_i;
        end
    end

    // Register the reset request as a single-cycle pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
        end
    end

    assign rst_req_o = req_q;
    assign cfg_bad_o = bad;
endmodule

// File: rtl/wdog_chk.sv
// Property checker for the windowed watchdog, bound to the top module.
module wdog_chk #(
    parameter int         DATA_W = 8,
    parameter logic [7:0] KEY    = 8'hAC,
    parameter int         CNT_W  = 17
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              osc_lock_i,
    input logic              halt_i,
    input logic              stop_i,
    input logic              osc_off_i,
    input logic              kick_valid_i,
    input logic [DATA_W-1:0] kick_data_i,
    input logic              rst_req_o,
    input logic              cfg_bad_o,
    input logic              win_open_o,
    input logic [CNT_W-1:0]  count_o
);
    // R6
    req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !kick_valid_i) |=> $stable(count_o));

    // R7
    bad_cfg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_bad_o |-> (count_o == '0));

    // R7
    bad_cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_bad_o && $past(cfg_bad_o)) |-> !rst_req_o);

    // R8
    sleep_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!osc_lock_i && (halt_i || stop_i) && !kick_valid_i) |=> $stable(count_o));

    // R9
    osc_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!osc_lock_i && osc_off_i && !kick_valid_i) |=> $stable(count_o));

    // R10
    locked_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_lock_i && tick_i && !cfg_bad_o && !kick_valid_i) |=> (count_o != $past(count_o)));

    // R5
    wrong_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_valid_i && !cfg_bad_o && (kick_data_i != DATA_W'(KEY))) |=> rst_req_o);

    // R4
    good_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_valid_i && !cfg_bad_o && win_open_o && (kick_data_i == DATA_W'(KEY)))
        |=> (!rst_req_o && (count_o == '0)));
endmodule

bind win_watchdog wdog_chk #(
    .DATA_W (DATA_W),
    .KEY    (KEY),
    .CNT_W  (CNT_W)
) i_wdog_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .osc_lock_i   (osc_lock_i),
    .halt_i       (halt_i),
    .stop_i       (stop_i),
    .osc_off_i    (osc_off_i),
    .kick_valid_i (kick_valid_i),
    .kick_data_i  (kick_data_i),
    .rst_req_o    (rst_req_o),
    .cfg_bad_o    (cfg_bad_o),
    .win_open_o   (win_open_o),
    .count_o      (count_o)
);

// File: tb/test_win_watchdog.sv
// Self-checking bench: a vector table of restart writes, then directed tests.
module test_win_watchdog;
    localparam int CNT_W = 17;
    localparam int NVEC  = 13;

    typedef struct packed {
        logic [2:0]       n;
        logic [1:0]       w;
        logic [CNT_W-1:0] at;
        logic [7:0]       d;
        logic             rst;
    } vec_t;

    // Period select, window select, count at write, byte, reset expected.
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 2'd0, 17'd1535, 8'hAC, 1'b1},
        '{3'd1, 2'd0, 17'd1536, 8'hAC, 1'b0},
        '{3'd1, 2'd1, 17'd1023, 8'hAC, 1'b1},
        '{3'd1, 2'd1, 17'd1024, 8'hAC, 1'b0},
        '{3'd1, 2'd2, 17'd511,  8'hAC, 1'b1},
        '{3'd1, 2'd2, 17'd512,  8'hAC, 1'b0},
        '{3'd1, 2'd3, 17'd0,    8'hAC, 1'b0},
        '{3'd1, 2'd3, 17'd2047, 8'hAC, 1'b0},
        '{3'd1, 2'd3, 17'd100,  8'h55, 1'b1},
        '{3'd0, 2'd1, 17'd511,  8'hAC, 1'b1},
        '{3'd0, 2'd1, 17'd512,  8'hAC, 1'b0},
        '{3'd2, 2'd0, 17'd3071, 8'hAC, 1'b1},
        '{3'd2, 2'd0, 17'd3072, 8'hAC, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [2:0]       psel = 3'd1;
    logic [1:0]       wsel = 2'd0;
    logic             lock = 1'b0;
    logic             halt = 1'b0;
    logic             stop = 1'b0;
    logic             osc_off = 1'b0;
    logic             kv = 1'b0;
    logic [7:0]       kd = 8'h00;
    logic             rst_req;
    logic             cfg_bad;
    logic             win_open;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int failures = 0;
    int c = 0;

    always #10 clk = ~clk;

    win_watchdog i_win_watchdog (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .period_sel_i (psel),
        .window_sel_i (wsel),
        .osc_lock_i   (lock),
        .halt_i       (halt),
        .stop_i       (stop),
        .osc_off_i    (osc_off),
        .kick_valid_i (kv),
        .kick_data_i  (kd),
        .rst_req_o    (rst_req),
        .cfg_bad_o    (cfg_bad),
        .win_open_o   (win_open),
        .count_o      (count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Hold reset for two edges with the given setting, then release at a falling edge.
    task automatic do_reset(input logic [2:0] n, input logic [1:0] w);
        @(negedge clk);
        rst_n = 1'b0;
        psel  = n;
        wsel  = w;
        kv    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_count(input int target);
        while (int'(count) != target) @(negedge clk);
    endtask

    task automatic kick(input logic [7:0] d);
        kv = 1'b1;
        kd = d;
        @(negedge clk);
        kv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run hung actual=0 expected=1");
        finish_run();
    end

    initial begin
        // R11 reset state
        do_reset(3'd1, 2'd0);
        check("R11", "count after reset", int'(count), 0);
        check("R11", "rst_req after reset", int'(rst_req), 0);
        check("R11", "cfg_bad after reset", int'(cfg_bad), 0);
        check("R3", "window closed at count 0, W=0", int'(win_open), 0);
        tick = 1'b1;

        // Vector table: R3, R4, R5 and R12 at window thresholds.
        for (int i = 0; i < NVEC; i++) begin
            do_reset(VECS[i].n, VECS[i].w);
            wait_count(int'(VECS[i].at));
            check(VECS[i].rst ? "R3" : "R4", $sformatf("vec %0d window", i),
                  int'(win_open), (VECS[i].d == 8'hAC) ? int'(!VECS[i].rst) : 1);
            kick(VECS[i].d);
            check(VECS[i].rst ? "R5" : (i == 7 ? "R12" : "R4"), $sformatf("vec %0d rst_req", i),
                  int'(rst_req), int'(VECS[i].rst));
            check("R4", $sformatf("vec %0d count cleared", i), int'(count), 0);
        end

        // R1 overflow at 2^10 strobes, R6 single-cycle pulse.
        do_reset(3'd0, 2'd3);
        wait_count(1023);
        @(negedge clk);
        check("R1", "overflow rst_req", int'(rst_req), 1);
        check("R1", "overflow clears count", int'(count), 0);
        @(negedge clk);
        check("R6", "pulse is single cycle", int'(rst_req), 0);
        check("R6", "count restarts", int'(count), 1);

        // R6 configuration captured again at the reset request only.
        do_reset(3'd0, 2'd3);
        psel = 3'd1;
        wsel = 2'd0;
        @(negedge clk);
        check("R11", "live inputs ignored before request", int'(win_open), 1);
        wait_count(1023);
        @(negedge clk);
        check("R6", "request at old period", int'(rst_req), 1);
        check("R6", "new window applied", int'(win_open), 0);
        wait_count(1024);
        check("R6", "no overflow at old period", int'(rst_req), 0);

        // R2 counting only on strobes.
        do_reset(3'd2, 2'd3);
        repeat (10) @(negedge clk);
        c = int'(count);
        tick = 1'b0;
        repeat (10) @(negedge clk);
        check("R2", "no strobe holds count", int'(count), c);
        for (int k = 0; k < 10; k++) begin
            tick = (k % 2 == 0);
            @(negedge clk);
        end
        check("R2", "half rate strobes", int'(count), c + 5);
        tick = 1'b1;

        // R8 halt and stop freeze with lock 0, resume from held value.
        lock = 1'b0;
        c = int'(count);
        halt = 1'b1;
        repeat (20) @(negedge clk);
        check("R8", "halt freezes", int'(count), c);
        halt = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", "resume after halt", int'(count), c + 5);
        c = int'(count);
        stop = 1'b1;
        repeat (20) @(negedge clk);
        check("R8", "stop freezes", int'(count), c);
        stop = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", "resume after stop", int'(count), c + 5);

        // R9 oscillator stop freezes with lock 0.
        c = int'(count);
        osc_off = 1'b1;
        repeat (20) @(negedge clk);
        check("R9", "osc off freezes", int'(count), c);
        osc_off = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "resume after osc off", int'(count), c + 3);

        // R10 lock 1 keeps counting.
        lock = 1'b1;
        c = int'(count);
        halt = 1'b1;
        repeat (20) @(negedge clk);
        check("R10", "halt ignored when locked", int'(count), c + 20);
        halt = 1'b0;
        stop = 1'b1;
        osc_off = 1'b1;
        repeat (20) @(negedge clk);
        check("R10", "stop and osc off ignored when locked", int'(count), c + 40);
        stop = 1'b0;
        osc_off = 1'b0;
        lock = 1'b0;

        // R7 prohibited configuration.
        do_reset(3'd0, 2'd0);
        check("R7", "flag raised", int'(cfg_bad), 1);
        repeat (50) @(negedge clk);
        check("R7", "count held at zero", int'(count), 0);
        kick(8'h12);
        check("R7", "write ignored, no request", int'(rst_req), 0);
        do_reset(3'd0, 2'd1);
        check("R7", "flag clears with legal setting", int'(cfg_bad), 0);

        finish_run();
    end
endmodule